// File: doc/BRIEF.md
# Reference-Edge Tick Phase Servo

This unit keeps a once-per-second calendar tick in step with an external reference that is more accurate than the crystal, such as a 50 Hz or 60 Hz mains waveform. The tick itself still comes from the 32.768 kHz crystal domain. The unit only asks the prescaler to move the tick phase by one 256 Hz period, earlier or later, when the reference shows that the tick has drifted. The reference is synchronized, then sampled on each 256 Hz strobe. A rising edge counts when the sampled level is high on one strobe and was low on the strobe before.

At every tick the unit looks for the nearest reference edge within a window of ±WIN strobe periods around the tick. An edge before the tick means the tick is late, so the unit asks for an advance. An edge after the tick means the tick is early, so it asks for a delay. An edge on the tick strobe itself means the two are aligned, and no request is made. If the window closes with no edge, that second counts as a miss. After LOST_SECS misses in a row the reference is flagged as absent, and requests stop until an edge is found again.

Top module: `tick_phase_servo`

## Requirements
- R1: After reset, corr_valid_o and ref_lost_o are both 0.
- R2: A reference rising edge is seen on a strobe only when the synchronized level is 1 on that strobe and was 0 on the previous strobe. A steady high level is not an edge. ref_i must be stable at least 3 clock cycles before the strobe. A tick is taken only when tick_i is 1 in the same cycle as strobe_i.
- R3: An edge on the tick strobe itself counts as "found" and produces no correction.
- R4: Let the nearest earlier edge be d strobes before the tick, with 1 ≤ d ≤ WIN, and let no edge fall less than d strobes after the tick. Then an advance request is made: corr_valid_o=1 and corr_dir_o=1. It appears in the cycle after the strobe that lies d strobes after the tick.
- R5: Let the first later edge be p strobes after the tick, with 1 ≤ p ≤ WIN, and let p be smaller than the earlier-edge distance. Then a delay request is made: corr_valid_o=1 and corr_dir_o=0. It appears in the cycle after that strobe.
- R6: If the earlier and later edges are the same distance from the tick, the request is an advance (corr_dir_o=1).
- R7: If no edge falls within ±WIN strobes (WIN=7), no request is made for that second. The window closes at the strobe WIN strobes after the tick, and that second counts as a miss.
- R8: A request lasts exactly one clock cycle. It always follows a strobe cycle, and there is at most one per second.
- R9: ref_lost_o goes to 1 in the cycle after the window close that completes LOST_SECS=4 consecutive misses. While ref_lost_o=1 no request is made. A found edge clears ref_lost_o, but the window that finds it still makes no request.
- R10: While en_i=0, no request is made, ref_lost_o is 0 and any open window is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Alignment enable |
| ref_i | input | 1 | Asynchronous reference signal |
| strobe_i | input | 1 | One-cycle 256 Hz sampling strobe |
| tick_i | input | 1 | 1 Hz tick, valid only together with strobe_i |
| corr_valid_o | output | 1 | One-cycle phase-correction request |
| corr_dir_o | output | 1 | 1 = advance tick, 0 = delay tick |
| ref_lost_o | output | 1 | Reference declared absent |

## Verification
Every result is registered on the clock edge that carries the strobe which decides it. corr_valid_o, corr_dir_o and ref_lost_o therefore change one cycle after that strobe. Reference levels need the two synchronizer stages before they are seen. The bench sets ref_i four cycles before each strobe, pulses the strobe for one cycle, and samples all outputs on the falling edge that follows. It checks again one cycle later that the request pulse has dropped. A model in the bench sweeps earlier-edge and later-edge distances on both sides of the window limit. For each strobe it works out which strobe decides the second, and compares the outputs against that strobe alone.

// File: rtl/tick_align_pkg.sv
package tick_align_pkg;
  typedef enum logic {
    DIR_DELAY   = 1'b0,
    DIR_ADVANCE = 1'b1
  } corr_dir_e;

  typedef struct packed {
    logic      valid;
    corr_dir_e dir;
  } corr_req_t;
endpackage

// File: rtl/tick_ref_sampler.sv
module tick_ref_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic strobe_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
      if (strobe_i) prev_q <= level;
    end
  end

  assign edge_o = strobe_i & level & ~prev_q;
endmodule

// File: rtl/tick_window_tracker.sv
module tick_window_tracker
  import tick_align_pkg::*;
#(
  parameter int unsigned WIN = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      strobe_i,
  input  logic      tick_i,
  input  logic      edge_i,
  output logic      found_o,
  output logic      miss_o,
  output corr_req_t corr_o
);
  localparam int unsigned DW = $clog2(WIN + 2);
  localparam logic [DW-1:0] NONE  = DW'(WIN + 1);
  localparam logic [DW-1:0] WIN_W = DW'(WIN);

  logic [DW-1:0] since_q, since_d, since_nxt;
  logic [DW-1:0] pcnt_q, pcnt_d;
  logic [DW-1:0] dbef_q, dbef_d;
  logic          busy_q, busy_d;

  // strobes since the last edge, saturating at NONE
  assign since_nxt = edge_i ? '0 : ((since_q == NONE) ? NONE : DW'(since_q + 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= NONE;
      pcnt_q  <= '0;
      dbef_q  <= NONE;
      busy_q  <= 1'b0;
    end else begin
      since_q <= since_d;
      pcnt_q  <= pcnt_d;
      dbef_q  <= dbef_d;
      busy_q  <= busy_d;
    end
  end

  always_comb begin
    since_d = since_q;
    pcnt_d  = pcnt_q;
    dbef_d  = dbef_q;
    busy_d  = busy_q;
    found_o = 1'b0;
    miss_o  = 1'b0;
    corr_o  = '{valid: 1'b0, dir: DIR_DELAY};
    if (!en_i) begin
      since_d = NONE;
      busy_d  = 1'b0;
    end else if (strobe_i) begin
      since_d = since_nxt;
      if (tick_i) begin
        busy_d = 1'b0;
        if (edge_i) begin
          found_o = 1'b1;
        end else begin
          busy_d = 1'b1;
          pcnt_d = DW'(1);
          dbef_d = since_nxt;
        end
      end else if (busy_q) begin
        if (edge_i && (pcnt_q < dbef_q)) begin
          found_o = 1'b1;
          corr_o  = '{valid: 1'b1, dir: DIR_DELAY};
          busy_d  = 1'b0;
        end else if (pcnt_q == dbef_q) begin
          // earlier edge wins ties
          found_o = 1'b1;
          corr_o  = '{valid: 1'b1, dir: DIR_ADVANCE};
          busy_d  = 1'b0;
        end else if (pcnt_q == WIN_W) begin
          miss_o = 1'b1;
          busy_d = 1'b0;
        end else begin
          pcnt_d = DW'(pcnt_q + 1'b1);
        end
      end
    end
  end

  AST_PCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (pcnt_q >= DW'(1) && pcnt_q <= WIN_W)); // R7
  AST_SINCE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= NONE); // R4
endmodule

// File: rtl/tick_presence_mon.sv
module tick_presence_mon #(
  parameter int unsigned LOST_SECS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic found_i,
  input  logic miss_i,
  output logic lost_o
);
  localparam int unsigned MW = $clog2(LOST_SECS + 1);
  localparam logic [MW-1:0] LIMIT = MW'(LOST_SECS);

  logic [MW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          miss_q <= '0;
    else if (!en_i || found_i)            miss_q <= '0;
    else if (miss_i && miss_q != LIMIT)   miss_q <= MW'(miss_q + 1'b1);
  end

  assign lost_o = (miss_q == LIMIT);

  AST_MISS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q <= LIMIT); // R9
  AST_FOUND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_i |=> !lost_o); // R9
endmodule

// File: rtl/tick_phase_servo.sv
module tick_phase_servo
  import tick_align_pkg::*;
#(
  parameter int unsigned WIN         = 7,
  parameter int unsigned LOST_SECS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_i,
  input  logic strobe_i,
  input  logic tick_i,
  output logic corr_valid_o,
  output logic corr_dir_o,
  output logic ref_lost_o
);
  logic      ref_edge;
  logic      found, miss;
  corr_req_t corr_req;
  logic      corr_valid_q;
  corr_dir_e corr_dir_q;

  tick_ref_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ref_i),
    .strobe_i (strobe_i),
    .edge_o   (ref_edge)
  );

  tick_window_tracker #(.WIN(WIN)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .strobe_i (strobe_i),
    .tick_i   (tick_i),
    .edge_i   (ref_edge),
    .found_o  (found),
    .miss_o   (miss),
    .corr_o   (corr_req)
  );

  tick_presence_mon #(.LOST_SECS(LOST_SECS)) u_presence (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .found_i (found),
    .miss_i  (miss),
    .lost_o  (ref_lost_o)
  );

  // lost flag sampled before this window's update: recovering window stays silent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_valid_q <= 1'b0;
      corr_dir_q   <= DIR_DELAY;
    end else begin
      corr_valid_q <= corr_req.valid & en_i & ~ref_lost_o;
      if (corr_req.valid) corr_dir_q <= corr_req.dir;
    end
  end

  assign corr_valid_o = corr_valid_q;
  assign corr_dir_o   = corr_dir_q;

  AST_CORR_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> $past(strobe_i)); // R8
  AST_CORR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |=> !corr_valid_o); // R8
  AST_NO_CORR_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> !$past(ref_lost_o)); // R9
  AST_NO_CORR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> $past(en_i)); // R10
  AST_LOST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !ref_lost_o); // R10
endmodule

// File: tb/tick_phase_servo_tb.sv
module tick_phase_servo_tb;
  localparam int WIN  = 7;
  localparam int LOST = 4;
  localparam int NO   = 99;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ref_s = 1'b0, strobe = 1'b0, tick = 1'b0;
  logic corr_valid, corr_dir, ref_lost;

  int n_chk = 0, n_bad = 0;
  int m_miss = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  tick_phase_servo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ref_i(ref_s),
    .strobe_i(strobe), .tick_i(tick),
    .corr_valid_o(corr_valid), .corr_dir_o(corr_dir), .ref_lost_o(ref_lost)
  );

  task automatic chk(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one strobe period; ref level settles 4 cycles before the strobe
  task automatic do_strobe(input bit lvl, input bit tk,
                           output bit gv, output bit gd, output bit gl);
    @(negedge clk); ref_s = lvl;
    repeat (4) @(negedge clk);
    strobe = 1'b1; tick = tk;
    @(negedge clk);
    strobe = 1'b0; tick = 1'b0;
    gv = corr_valid; gd = corr_dir; gl = ref_lost;
  endtask

  // one second: strobes -10..+10 around the tick
  task automatic run_second(input int bd, input int ad, input bit hold, input string tag);
    bit gv, gd, gl, lvl, done, ev, ed, found, miss;
    done = 0;
    for (int s = -10; s <= 10; s++) begin
      if (hold) lvl = (bd != NO) && (s >= -bd);
      else      lvl = (bd != NO && s == -bd) || (ad != NO && s == ad);
      do_strobe(lvl, s == 0, gv, gd, gl);
      ev = 0; ed = 0; found = 0; miss = 0;
      if (!en) m_miss = 0;
      else if (!done) begin
        if (s == 0 && bd == 0) begin found = 1; done = 1; end
        else if (s >= 1 && s <= WIN && bd != 0) begin
          if (ad == s && s < bd) begin found = 1; ev = 1; ed = 0; done = 1; end
          else if (s == bd)      begin found = 1; ev = 1; ed = 1; done = 1; end
          else if (s == WIN)     begin miss = 1; done = 1; end
        end
      end
      if (found) begin
        if (m_miss == LOST) ev = 0;
        m_miss = 0;
      end else if (miss && m_miss < LOST) m_miss++;
      chk(tag, gv, ev, $sformatf("corr_valid s=%0d bd=%0d ad=%0d", s, bd, ad));
      if (ev) chk(tag, gd, ed, $sformatf("corr_dir s=%0d bd=%0d ad=%0d", s, bd, ad));
      chk(gl ? "R9" : tag, gl, (m_miss == LOST), $sformatf("ref_lost s=%0d", s));
      if (ev) begin
        @(negedge clk);
        chk("R8", corr_valid, 0, "pulse width");
      end
    end
  endtask

  function automatic string tag_of(input int bd, input int ad);
    if (bd == 0) return "R3";
    if (ad <= WIN && ad < bd) return "R5";
    if (bd <= WIN && ad == bd) return "R6";
    if (bd <= WIN) return "R4";
    return "R7";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", corr_valid, 0, "corr_valid in reset");
    chk("R1", ref_lost, 0, "ref_lost in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", corr_valid, 0, "corr_valid after reset");
    chk("R1", ref_lost, 0, "ref_lost after reset");
    en = 1'b1;

    // sweep earlier/later edge distances across the window limit
    for (int bd = 0; bd <= 10; bd++)
      for (int ad = 1; ad <= 10; ad++) begin
        int b = (bd == 10) ? NO : bd;
        int a = (ad == 10) ? NO : ad;
        run_second(b, a, 0, tag_of(b, a));
      end

    // steady high level after the edge is not another edge
    run_second(3, NO, 1, "R2");
    run_second(NO, NO, 0, "R2");

    // loss after consecutive misses, silent recovery, then normal service
    for (int k = 0; k < LOST + 1; k++) run_second(NO, NO, 0, "R9");
    run_second(2, NO, 0, "R9");
    run_second(2, NO, 0, "R9");
    run_second(NO, 3, 0, "R9");

    // disabled: no request, loss state cleared
    for (int k = 0; k < LOST; k++) run_second(NO, NO, 0, "R9");
    en = 1'b0;
    run_second(4, NO, 0, "R10");
    run_second(NO, 2, 0, "R10");
    en = 1'b1;
    run_second(5, NO, 0, "R10");

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule